// File: doc/BRIEF.md
# Mirrored Stable Store Controller with Write Proof

This block fronts a small battery-backed word store that is kept as two identical copies. A host talks to it through a narrow command port: one 16-bit bus carries an address on the cycle a command starts and data words on later strobes. Every word travels with an odd parity bit. A parity fault ends the command at once.

Runaway software is kept out of the store by a proof rule. Before any write lands, the host must quote the value the word holds now. For a multi-word record, only the first word needs this proof. The controller adds up the record's data words and closes the record with a checksum word. A record cut short is therefore left without a valid checksum, and a later verify pass shows this. Writes normally go to both copies on the same clock edge. A per-copy mask also lets recovery code read or rewrite one copy alone, so a good copy can repair a bad one.

The controller is a single state machine. Its states are:

- `S_IDLE`: waiting for a command.
- `S_GET_LEN`: waiting for the record length.
- `S_GET_PROOF`: waiting for the proof word.
- `S_DATA`: taking data words.
- `S_SUM`: writing the checksum word.
- `S_READ`: capturing a read.
- `S_VFY_RD` and `S_VFY_ACC`: reading the copies and adding up each word, alternating one cycle each.
- `S_DONE`: a one-cycle completion.

Its transitions are:

- `S_IDLE` goes to `S_GET_PROOF` for a word write, to `S_GET_LEN` for a record write or a verify, to `S_READ` for a read, or to `S_DONE` on a rejected start.
- `S_GET_LEN` goes to `S_GET_PROOF` for a record write, to `S_VFY_RD` for a verify, or to `S_DONE` on an error.
- `S_GET_PROOF` goes to `S_DATA`, or to `S_DONE` on a mismatch or a parity fault.
- `S_DATA` goes to `S_SUM` after the last data word of a record, or to `S_DONE` after a single word or on a fault.
- `S_SUM` and `S_READ` go to `S_DONE`.
- `S_VFY_ACC` goes back to `S_VFY_RD`, or to `S_DONE` after the last word.
- `S_DONE` goes to `S_IDLE`.

Top module: `stable_store`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_data`, `copy_ok` and `diff_seen` are all zero. `done` is high for exactly one cycle per command.
- R2: For a word write (`cmd_op`=0) or a record write (`cmd_op`=1), the proof word must equal the current contents of the first addressed word. The proof is compared against copy A when `cmd_copy[0]`=1, and against copy B otherwise. On a mismatch, nothing is written and `err`=1.
- R3: A word write with a correct proof stores the data word in every copy whose `cmd_copy` bit is set. Bit 0 selects copy A and bit 1 selects copy B. `err` is then 0.
- R4: A record write is sent as follows: the address at start, then a length N (2..depth, counting the checksum word), then the proof, then N-1 data words. The data words go to consecutive addresses, and only the first of them is proof-checked. The word at address+N-1 is then written with the 16-bit two's-complement negation of the sum of the data words. A record aborted midway leaves that word unwritten.
- R5: With `cmd_copy`=3, both copies are written on the same edge. `done` rises one cycle after the edge that takes the last word of a word write.
- R6: A read (`cmd_op`=2) returns copy A when `cmd_copy[0]`=1 and copy B otherwise. Writes with only one mask bit set leave the other copy untouched.
- R7: Every word whose strobe the controller acts on, including the start word, must have odd parity over `bus_par` and `bus_in`. A parity fault ends the command with `err`=2, and nothing is written by that word.
- R8: A verify (`cmd_op`=3) takes the address at start and a length N. It then sets `copy_ok[i]` when the N words of copy i sum to zero. It sets `diff_seen` when any of the N word pairs differ between the copies.
- R9: `cmd_start` is ignored while `busy` is high. `data_stb` is ignored in `S_IDLE` and `S_DONE`.
- R10: The command is rejected with `err`=3 in two cases: when `cmd_copy`=0 for anything but a verify, and when a length is below 2 or above the store depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Starts a command; `bus_in` holds the address |
| cmd_op | input | 2 | 0 word write, 1 record write, 2 read, 3 verify |
| cmd_copy | input | 2 | Copy mask: bit 0 copy A, bit 1 copy B |
| bus_in | input | 16 | Shared address / data word |
| bus_par | input | 1 | Odd parity bit for `bus_in` |
| data_stb | input | 1 | A length, proof or data word is on `bus_in` |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 proof mismatch, 2 parity, 3 bad command |
| rd_data | output | 16 | Word returned by the last read |
| copy_ok | output | 2 | Per-copy checksum result of the last verify |
| diff_seen | output | 1 | The last verify found copies that differ |

## Verification
A corrupted address or word counter shows up at once in the verify results. The checksum lands one word off, so `copy_ok` drops on the very next verify of that record. A stale copy mask surfaces on the next single-copy read, because that read returns the copy that should not have changed. A proof comparator fed from the wrong copy rejects a correct proof, which gives `err`=1 in the cycle after the proof strobe. A state machine stuck off `S_IDLE` holds `busy` high and never pulses `done`, so the next command never completes.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_BLOCK  = 2'd1,
        OP_READ   = 2'd2,
        OP_VERIFY = 2'd3
    } ss_op_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_PROOF  = 2'd1,
        ERR_PARITY = 2'd2,
        ERR_CMD    = 2'd3
    } ss_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GET_LEN,
        S_GET_PROOF,
        S_DATA,
        S_SUM,
        S_READ,
        S_VFY_RD,
        S_VFY_ACC,
        S_DONE
    } ss_state_e;

endpackage

// File: rtl/ss_bank.sv
// One copy of the store: synchronous write, registered read (old data on a
// same-cycle write to the same address).
module ss_bank #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/ss_parity_chk.sv
// Odd parity across the data word and its parity bit.
module ss_parity_chk #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    output logic          ok
);
    assign ok = ^{par, data};
endmodule

// File: rtl/ss_sum_acc.sv
// Modulo-2^DW running sum, cleared at each command start.
module ss_sum_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + din;
        end
    end
endmodule

// File: rtl/stable_store.sv
module stable_store
    import ss_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_op,
    input  logic [1:0]    cmd_copy,
    input  logic [DW-1:0] bus_in,
    input  logic          bus_par,
    input  logic          data_stb,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    copy_ok,
    output logic          diff_seen
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam int NCOPY = 2;

    ss_state_e        state_q, state_d;
    ss_op_e           op_q;
    ss_err_e          err_q;
    logic [NCOPY-1:0] mask_q;
    logic [AW-1:0]    addr_q;
    logic [CW-1:0]    cnt_q;
    logic [DW-1:0]    rd_q;
    logic [NCOPY-1:0] ok_q;
    logic             diff_q;

    // ---------------- shared decode ----------------
    ss_op_e      op_in;
    logic        par_ok;
    logic        mask_bad;
    logic        len_ok;
    logic [31:0] len_w;
    logic        proof_ok;
    logic        word_take;
    logic        vfy_take;
    logic        last;
    logic [DW-1:0] prim_rd;
    logic [DW-1:0] checksum;

    logic [AW-1:0]    bank_addr;
    logic [NCOPY-1:0] bank_we;
    logic [DW-1:0]    bank_wdata;
    logic [DW-1:0]    bank_rdata [NCOPY];
    logic [DW-1:0]    acc_sum    [NCOPY];
    logic [DW-1:0]    acc_din    [NCOPY];
    logic [DW-1:0]    sum_next   [NCOPY];
    logic [NCOPY-1:0] acc_add;
    logic             acc_clr;

    ss_parity_chk #(.DW(DW)) u_par (
        .data (bus_in),
        .par  (bus_par),
        .ok   (par_ok)
    );

    generate
        for (genvar g = 0; g < NCOPY; g++) begin : g_copy
            ss_bank #(.AW(AW), .DW(DW)) u_bank (
                .clk   (clk),
                .we    (bank_we[g]),
                .addr  (bank_addr),
                .wdata (bank_wdata),
                .rdata (bank_rdata[g])
            );
            ss_sum_acc #(.DW(DW)) u_acc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (acc_clr),
                .add   (acc_add[g]),
                .din   (acc_din[g]),
                .sum   (acc_sum[g])
            );
            assign sum_next[g] = acc_sum[g] + bank_rdata[g];
        end
    endgenerate

    assign op_in     = ss_op_e'(cmd_op);
    assign mask_bad  = (op_in != OP_VERIFY) && (cmd_copy == 2'b00);
    assign len_w     = 32'(bus_in);
    assign len_ok    = (len_w >= 32'd2) && (len_w <= 32'(DEPTH));
    assign prim_rd   = mask_q[0] ? bank_rdata[0] : bank_rdata[1];
    assign proof_ok  = (bus_in == prim_rd);
    assign word_take = (state_q == S_DATA) && data_stb && par_ok;
    assign vfy_take  = (state_q == S_VFY_ACC);
    assign last      = (cnt_q == CW'(1));
    assign checksum  = '0 - acc_sum[0];

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_start) begin
                    if (!par_ok || mask_bad) begin
                        state_d = S_DONE;
                    end else begin
                        unique case (op_in)
                            OP_WRITE:  state_d = S_GET_PROOF;
                            OP_BLOCK:  state_d = S_GET_LEN;
                            OP_READ:   state_d = S_READ;
                            OP_VERIFY: state_d = S_GET_LEN;
                        endcase
                    end
                end
            end
            S_GET_LEN: begin
                if (data_stb) begin
                    if (!par_ok || !len_ok)   state_d = S_DONE;
                    else if (op_q == OP_BLOCK) state_d = S_GET_PROOF;
                    else                       state_d = S_VFY_RD;
                end
            end
            S_GET_PROOF: begin
                if (data_stb) begin
                    if (!par_ok || !proof_ok) state_d = S_DONE;
                    else                      state_d = S_DATA;
                end
            end
            S_DATA: begin
                if (data_stb) begin
                    if (!par_ok)               state_d = S_DONE;
                    else if (last)             state_d = (op_q == OP_BLOCK) ? S_SUM : S_DONE;
                end
            end
            S_SUM:     state_d = S_DONE;
            S_READ:    state_d = S_DONE;
            S_VFY_RD:  state_d = S_VFY_ACC;
            S_VFY_ACC: state_d = last ? S_DONE : S_VFY_RD;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- command datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_WRITE;
            err_q  <= ERR_NONE;
            mask_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            ok_q   <= '0;
            diff_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_start) begin
                        op_q   <= op_in;
                        mask_q <= cmd_copy;
                        addr_q <= bus_in[AW-1:0];
                        cnt_q  <= CW'(1);
                        ok_q   <= '0;
                        diff_q <= 1'b0;
                        if (!par_ok)       err_q <= ERR_PARITY;
                        else if (mask_bad) err_q <= ERR_CMD;
                        else               err_q <= ERR_NONE;
                    end
                end
                S_GET_LEN: begin
                    if (data_stb) begin
                        if (!par_ok)               err_q <= ERR_PARITY;
                        else if (!len_ok)          err_q <= ERR_CMD;
                        else if (op_q == OP_BLOCK) cnt_q <= CW'(bus_in) - CW'(1);
                        else                       cnt_q <= CW'(bus_in);
                    end
                end
                S_GET_PROOF: begin
                    if (data_stb) begin
                        if (!par_ok)        err_q <= ERR_PARITY;
                        else if (!proof_ok) err_q <= ERR_PROOF;
                    end
                end
                S_DATA: begin
                    if (data_stb) begin
                        if (!par_ok) begin
                            err_q <= ERR_PARITY;
                        end else begin
                            addr_q <= addr_q + AW'(1);
                            cnt_q  <= cnt_q - CW'(1);
                        end
                    end
                end
                S_READ: rd_q <= prim_rd;
                S_VFY_ACC: begin
                    addr_q <= addr_q + AW'(1);
                    cnt_q  <= cnt_q - CW'(1);
                    if (bank_rdata[0] != bank_rdata[1]) diff_q <= 1'b1;
                    if (last) ok_q <= {sum_next[1] == '0, sum_next[0] == '0};
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs and bank controls ----------------
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE);
        bank_addr  = (state_q == S_IDLE) ? bus_in[AW-1:0] : addr_q;
        bank_we    = '0;
        if (word_take || state_q == S_SUM) bank_we = mask_q;
        bank_wdata = (state_q == S_SUM) ? checksum : bus_in;
        acc_clr    = (state_q == S_IDLE) && cmd_start;
        acc_add[0] = (word_take && op_q == OP_BLOCK) || vfy_take;
        acc_din[0] = vfy_take ? bank_rdata[0] : bus_in;
        acc_add[1] = vfy_take;
        acc_din[1] = bank_rdata[1];
    end

    assign err       = err_q;
    assign rd_data   = rd_q;
    assign copy_ok   = ok_q;
    assign diff_seen = diff_q;

    // ---------------- assertions ----------------
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_proof_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GET_PROOF && data_stb && par_ok && !proof_ok)
        |=> (done && err == 2'd1));

    assert_word_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && data_stb && par_ok && last && op_q == OP_WRITE)
        |=> done);

    assert_par_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && data_stb && !par_ok) |-> (bank_we == '0));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> ($stable(op_q) && $stable(mask_q)));

endmodule

// File: tb/sim_stable_store.sv
`timescale 1ns/1ps
module sim_stable_store;
    localparam logic [1:0] C_WR = 2'd0, C_BLK = 2'd1, C_RD = 2'd2, C_VF = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start, bus_par, data_stb;
    logic [1:0]  cmd_op, cmd_copy;
    logic [15:0] bus_in;
    logic        busy, done, diff_seen;
    logic [1:0]  err, copy_ok;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    stable_store u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_copy(cmd_copy), .bus_in(bus_in), .bus_par(bus_par),
        .data_stb(data_stb), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .copy_ok(copy_ok), .diff_seen(diff_seen)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    // {mask[2], wrong proof, bad data parity, addr[8], data[16], expected err[2]}
    localparam int NV = 9;
    localparam logic [29:0] VEC [NV] = '{
        {2'b11, 1'b0, 1'b0, 8'h10, 16'hA5A5, 2'd0},
        {2'b11, 1'b1, 1'b0, 8'h10, 16'h1234, 2'd1},
        {2'b01, 1'b0, 1'b0, 8'h11, 16'h0F0F, 2'd0},
        {2'b10, 1'b0, 1'b0, 8'h11, 16'hF00F, 2'd0},
        {2'b11, 1'b0, 1'b1, 8'h12, 16'h5555, 2'd2},
        {2'b00, 1'b0, 1'b0, 8'h13, 16'h7777, 2'd3},
        {2'b10, 1'b1, 1'b0, 8'h11, 16'h9999, 2'd1},
        {2'b11, 1'b0, 1'b0, 8'hFF, 16'hFFFF, 2'd0},
        {2'b01, 1'b0, 1'b0, 8'h10, 16'h0001, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic s, input logic [1:0] op, input logic [1:0] cp,
                       input logic [15:0] w, input logic stb, input logic badp);
        @(negedge clk);
        cmd_start = s;
        cmd_op    = op;
        cmd_copy  = cp;
        bus_in    = w;
        bus_par   = ~(^w) ^ badp;
        data_stb  = stb;
    endtask

    task automatic wait_done(input int base);
        put(1'b0, 2'd0, 2'd0, 16'h0, 1'b0, 1'b0);
        for (int k = 0; k < 400; k++) begin
            if (done_cnt != base) return;
            @(posedge clk); #1;
        end
        chk("R1 done never seen", 0, 1);
    endtask

    task automatic read_word(input logic [15:0] a, input logic [1:0] cp, output logic [15:0] v);
        int base;
        base = done_cnt;
        put(1'b1, C_RD, cp, a, 1'b0, 1'b0);
        wait_done(base);
        v = rd_data;
    endtask

    task automatic write_word(input logic [15:0] a, input logic [1:0] cp,
                              input logic [15:0] proof, input logic [15:0] d, input logic badp);
        int base;
        base = done_cnt;
        put(1'b1, C_WR, cp, a, 1'b0, 1'b0);
        put(1'b0, C_WR, cp, proof, 1'b1, 1'b0);
        put(1'b0, C_WR, cp, d, 1'b1, badp);
        wait_done(base);
    endtask

    task automatic verify(input logic [15:0] a, input logic [15:0] len);
        int base;
        base = done_cnt;
        put(1'b1, C_VF, 2'b00, a, 1'b0, 1'b0);
        put(1'b0, C_VF, 2'b00, len, 1'b1, 1'b0);
        wait_done(base);
    endtask

    task automatic blk4(input logic [15:0] a, input logic [15:0] proof,
                        input logic [15:0] d0, input logic [15:0] d1,
                        input logic [15:0] d2, input int badidx);
        int base;
        base = done_cnt;
        put(1'b1, C_BLK, 2'b11, a, 1'b0, 1'b0);
        put(1'b0, C_BLK, 2'b11, 16'd4, 1'b1, 1'b0);
        put(1'b0, C_BLK, 2'b11, proof, 1'b1, 1'b0);
        put(1'b0, C_BLK, 2'b11, d0, 1'b1, badidx == 0);
        put(1'b0, C_BLK, 2'b11, d1, 1'b1, badidx == 1);
        put(1'b0, C_BLK, 2'b11, d2, 1'b1, badidx == 2);
        wait_done(base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] oa, ob, va, vb, pf, cs, s_a, s_b;
        logic [15:0] oA [4];
        logic [15:0] oB [4];
        int base;

        cmd_start = 0; cmd_op = 0; cmd_copy = 0; bus_in = 0; bus_par = 1; data_stb = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 copy_ok", copy_ok, 0);
        chk("R1 diff_seen", diff_seen, 0);

        // ---- vector table: single-word writes ----
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            logic [1:0]  cp, xe;
            logic        wrong, badp;
            logic [15:0] ad, dt, ea, eb;
            string       tg;
            v = VEC[i];
            cp = v[29:28]; wrong = v[27]; badp = v[26];
            ad = {8'h00, v[25:18]}; dt = v[17:2]; xe = v[1:0];
            tg = (xe == 2'd1) ? "R2" : (xe == 2'd2) ? "R7" : (xe == 2'd3) ? "R10" :
                 (cp == 2'b11) ? "R3" : "R6";
            read_word(ad, 2'b01, oa);
            read_word(ad, 2'b10, ob);
            pf = cp[0] ? oa : ob;
            if (wrong) pf = pf ^ 16'h0001;
            write_word(ad, cp, pf, dt, badp);
            chk($sformatf("%s vec%0d err", tg, i), err, xe);
            read_word(ad, 2'b01, va);
            read_word(ad, 2'b10, vb);
            ea = (xe == 2'd0 && cp[0]) ? dt : oa;
            eb = (xe == 2'd0 && cp[1]) ? dt : ob;
            chk($sformatf("%s vec%0d copyA", tg, i), va, ea);
            chk($sformatf("%s vec%0d copyB", tg, i), vb, eb);
        end

        // ---- R5: mirrored write, done one cycle after the last word ----
        read_word(16'h0020, 2'b01, oa);
        base = done_cnt;
        put(1'b1, C_WR, 2'b11, 16'h0020, 1'b0, 1'b0);
        put(1'b0, C_WR, 2'b11, oa, 1'b1, 1'b0);
        put(1'b0, C_WR, 2'b11, 16'h3C3C, 1'b1, 1'b0);
        @(posedge clk); #1;
        chk("R5 done latency", done, 1);
        wait_done(base);
        read_word(16'h0020, 2'b01, va);
        read_word(16'h0020, 2'b10, vb);
        chk("R5 mirror A", va, 16'h3C3C);
        chk("R5 mirror B", vb, 16'h3C3C);

        // ---- R4: record write with checksum ----
        read_word(16'h0040, 2'b01, oa);
        blk4(16'h0040, oa, 16'h1111, 16'h2222, 16'h0F00, -1);
        chk("R4 record err", err, 0);
        cs = 16'h0000 - (16'h1111 + 16'h2222 + 16'h0F00);
        read_word(16'h0043, 2'b01, va);
        read_word(16'h0043, 2'b10, vb);
        chk("R4 checksum A", va, cs);
        chk("R4 checksum B", vb, cs);
        read_word(16'h0041, 2'b10, vb);
        chk("R4 unproved word", vb, 16'h2222);

        // ---- R8: verify of a good record ----
        verify(16'h0040, 16'd4);
        chk("R8 good copy_ok", copy_ok, 2'b11);
        chk("R8 good diff", diff_seen, 0);

        // ---- R6/R8: damage copy B alone, then verify ----
        read_word(16'h0041, 2'b10, ob);
        write_word(16'h0041, 2'b10, ob, 16'h2223, 1'b0);
        chk("R6 single-copy err", err, 0);
        verify(16'h0040, 16'd4);
        chk("R8 damaged copy_ok", copy_ok, 2'b01);
        chk("R8 damaged diff", diff_seen, 1);

        // ---- R6: repair B from A ----
        read_word(16'h0041, 2'b01, va);
        write_word(16'h0041, 2'b10, 16'h2223, va, 1'b0);
        verify(16'h0040, 16'd4);
        chk("R6 repaired copy_ok", copy_ok, 2'b11);
        chk("R6 repaired diff", diff_seen, 0);

        // ---- R4/R7: record cut by a parity fault ----
        for (int k = 0; k < 4; k++) begin
            read_word(16'h0060 + 16'(k), 2'b01, oA[k]);
            read_word(16'h0060 + 16'(k), 2'b10, oB[k]);
        end
        blk4(16'h0060, oA[0], 16'h0102, 16'h0304, 16'h0506, 1);
        chk("R7 record parity err", err, 2);
        read_word(16'h0060, 2'b10, vb);
        chk("R4 cut first word", vb, 16'h0102);
        read_word(16'h0061, 2'b01, va);
        chk("R7 faulty word not written", va, oA[1]);
        read_word(16'h0063, 2'b01, va);
        chk("R4 checksum slot untouched", va, oA[3]);
        s_a = 16'h0102 + oA[1] + oA[2] + oA[3];
        s_b = 16'h0102 + oB[1] + oB[2] + oB[3];
        verify(16'h0060, 16'd4);
        chk("R8 cut record copy_ok", copy_ok, {s_b == 16'h0, s_a == 16'h0});

        // ---- R9: start ignored while busy ----
        read_word(16'h0030, 2'b01, oa);
        base = done_cnt;
        put(1'b1, C_WR, 2'b11, 16'h0030, 1'b0, 1'b0);
        put(1'b1, C_RD, 2'b01, 16'h0031, 1'b0, 1'b0);
        put(1'b0, C_WR, 2'b11, oa, 1'b1, 1'b0);
        put(1'b0, C_WR, 2'b11, 16'h6A6A, 1'b1, 1'b0);
        wait_done(base);
        chk("R9 err", err, 0);
        read_word(16'h0030, 2'b10, vb);
        chk("R9 write survived", vb, 16'h6A6A);

        // ---- R10: bad lengths and empty mask ----
        verify(16'h0040, 16'd1);
        chk("R10 length 1", err, 3);
        verify(16'h0040, 16'h0101);
        chk("R10 length over depth", err, 3);
        base = done_cnt;
        put(1'b1, C_RD, 2'b00, 16'h0040, 1'b0, 1'b0);
        wait_done(base);
        chk("R10 read empty mask", err, 3);

        // ---- R7: parity fault on the start word ----
        base = done_cnt;
        put(1'b1, C_RD, 2'b01, 16'h0040, 1'b0, 1'b1);
        wait_done(base);
        chk("R7 start parity", err, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule